// File: doc/BRIEF.md
# Dimension-Order Hypercube Route Selector

This block makes the forwarding decision for a single node of a binary n-cube interconnect. Each node address is a DIM-bit vector, and every bit records the node's position along one dimension. The block receives two addresses: the address of the node it sits in and the destination address carried by the packet waiting at the head of the queue. It compares them and produces two results. The first is a one-hot port choice. That choice is either one of the DIM dimension links or the local delivery port. The second result is the number of hops still needed to reach the destination.

The route is fixed by dimension order. The block scans dimensions from 0 upward and picks the lowest dimension in which the two addresses differ. For a given source and destination, this always gives the same path. Moving across dimension i reaches the neighbour whose address is the current address with bit i inverted. After enough such moves the packet arrives, and the number of moves equals the Hamming distance between source and destination. This distance is never more than DIM.

The request enters through a valid/ready pair and the decision leaves through a valid/ready pair, with one register stage between them. The rules for back-pressure are as follows:
- A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high.
- `req_ready` is high when the result stage is empty, or when the result stage is being drained in that same cycle.
- A result that is presented while `rsp_ready` is low stays unchanged until it is accepted.

Top module: `hcube_route_sel`

## Requirements
- R1: Whenever `rsp_valid` is high, `rsp_port` has exactly one bit set.
- R2: If the current and destination addresses differ, `rsp_port[i]` is set for the lowest index i at which `cur_addr ^ dst_addr` has a 1. Bit positions 0..DIM-1 of `rsp_port` correspond to dimension links 0..DIM-1.
- R3: If the current and destination addresses are equal, only `rsp_port[DIM]` (the local delivery port) is set, and `rsp_hops` is 0.
- R4: `rsp_hops` equals the number of 1 bits in `cur_addr ^ dst_addr` for the accepted request.
- R5: A request accepted on an edge is presented, with `rsp_valid` high, immediately after that same edge. The latency is one cycle.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_port` and `rsp_hops` hold their values.
- R7: After reset, `rsp_valid` is low and `req_ready` is high.
- R8: A chain of selectors in which each hop inverts the chosen dimension bit reaches the destination after exactly the Hamming distance in hops. This is never more than DIM. From that point on, the local port is selected.
- R9: When a result is accepted and no new request is taken on the same edge, `rsp_valid` goes low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| cur_addr | input | DIM | Address of this node |
| dst_addr | input | DIM | Destination address of the head packet |
| rsp_valid | output | 1 | Routing decision present |
| rsp_ready | input | 1 | Downstream takes the decision this cycle |
| rsp_port | output | DIM+1 | One-hot port select, bit DIM = local delivery |
| rsp_hops | output | $clog2(DIM+1) | Remaining hop count |

## Verification
The hardest situation to reach from the ports is a stalled result that must survive while a different request is waiting. To create it, the bench first lowers `rsp_ready`, then lets one request into the register stage, and then places a second request with a different route on the inputs. It checks that `req_ready` falls and that the first decision stays unchanged over several cycles. It then releases the stall and confirms that the second decision follows. The complete-path requirement is checked with a chain of DIM+1 selector instances. In this chain, the bench inverts the chosen bit between stages, and it does this for every source and destination pair.

// File: rtl/hcube_route_pkg.sv
package hcube_route_pkg;
  localparam int unsigned DIM_DEFAULT = 4;

  function automatic int unsigned hop_width(input int unsigned dim);
    return (dim < 1) ? 1 : $clog2(dim + 1);
  endfunction
endpackage

// File: rtl/hcube_dim_pick.sv
module hcube_dim_pick #(
  parameter int unsigned DIM = 4
) (
  input  logic [DIM-1:0] diff,
  output logic [DIM:0]   port_sel
);
  logic found;

  always_comb begin
    port_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < int'(DIM); i++) begin
      if (diff[i] && !found) begin
        port_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
    if (!found) port_sel[DIM] = 1'b1;
  end
endmodule

// File: rtl/hcube_hop_count.sv
module hcube_hop_count #(
  parameter int unsigned DIM = 4,
  parameter int unsigned HW  = 3
) (
  input  logic [DIM-1:0] diff,
  output logic [HW-1:0]  hops
);
  always_comb begin
    hops = '0;
    for (int i = 0; i < int'(DIM); i++) begin
      hops = hops + HW'(diff[i]);
    end
  end
endmodule

// File: rtl/hcube_route_sel.sv
module hcube_route_sel
  import hcube_route_pkg::*;
#(
  parameter int unsigned DIM = DIM_DEFAULT,
  localparam int unsigned HW = hop_width(DIM),
  localparam int unsigned PW = DIM + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DIM-1:0] cur_addr,
  input  logic [DIM-1:0] dst_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [PW-1:0] rsp_port,
  output logic [HW-1:0] rsp_hops
);
  logic [DIM-1:0] addr_diff;
  logic [PW-1:0]  next_port;
  logic [HW-1:0]  next_hops;
  logic           valid_q;
  logic [PW-1:0]  port_q;
  logic [HW-1:0]  hops_q;

  assign addr_diff = cur_addr ^ dst_addr;

  hcube_dim_pick #(.DIM(DIM)) u_pick (
    .diff     (addr_diff),
    .port_sel (next_port)
  );

  hcube_hop_count #(.DIM(DIM), .HW(HW)) u_count (
    .diff (addr_diff),
    .hops (next_hops)
  );

  assign req_ready = !valid_q || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      port_q  <= '0;
      hops_q  <= '0;
    end else if (req_ready) begin
      valid_q <= req_valid;
      if (req_valid) begin
        port_q <= next_port;
        hops_q <= next_hops;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_port  = port_q;
  assign rsp_hops  = hops_q;
endmodule

// File: rtl/hcube_route_sel_chk.sv
module hcube_route_sel_chk #(
  parameter int unsigned DIM = 4,
  parameter int unsigned HW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [DIM:0]   rsp_port,
  input logic [HW-1:0]  rsp_hops
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_port) == 1);

  p_local_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_port[DIM]) |-> rsp_hops == '0);

  p_link_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_port[DIM]) |-> rsp_hops != '0);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_port) && $stable(rsp_hops));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  p_hops_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_hops <= HW'(DIM));
endmodule

bind hcube_route_sel hcube_route_sel_chk #(.DIM(DIM), .HW(HW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_port  (rsp_port),
  .rsp_hops  (rsp_hops)
);

// File: tb/tb_hcube_route_sel.sv
module tb_hcube_route_sel;
  localparam int DIM = 4;
  localparam int HW  = $clog2(DIM + 1);
  localparam int PW  = DIM + 1;
  localparam int NN  = 1 << DIM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [DIM-1:0] cur_addr = '0;
  logic [DIM-1:0] dst_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [PW-1:0] rsp_port;
  logic [HW-1:0] rsp_hops;

  int checks = 0;
  int fails  = 0;

  hcube_route_sel #(.DIM(DIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cur_addr(cur_addr), .dst_addr(dst_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_port(rsp_port), .rsp_hops(rsp_hops)
  );

  // chain of nodes: bench flips the chosen dimension bit between stages
  logic [DIM-1:0] ch_src = '0;
  logic [DIM-1:0] ch_dst = '0;
  logic           ch_go  = 1'b0;
  logic [DIM-1:0] node_addr [DIM+2];
  logic [DIM-1:0] addr_q    [DIM+1];
  logic           ch_vld    [DIM+2];
  logic [PW-1:0]  ch_port   [DIM+1];
  logic [HW-1:0]  ch_hops   [DIM+1];
  logic           ch_rdy    [DIM+1];

  assign node_addr[0] = ch_src;
  assign ch_vld[0]    = ch_go;

  for (genvar s = 0; s <= DIM; s++) begin : g_chain
    hcube_route_sel #(.DIM(DIM)) chain (
      .clk(clk), .rst_n(rst_n), .req_valid(ch_vld[s]), .req_ready(ch_rdy[s]),
      .cur_addr(node_addr[s]), .dst_addr(ch_dst), .rsp_valid(ch_vld[s+1]),
      .rsp_ready(1'b1), .rsp_port(ch_port[s]), .rsp_hops(ch_hops[s])
    );
    always_ff @(posedge clk) addr_q[s] <= node_addr[s];
    assign node_addr[s+1] = addr_q[s] ^ ch_port[s][DIM-1:0];
  end

  function automatic logic [PW-1:0] exp_port(input logic [DIM-1:0] a, input logic [DIM-1:0] b);
    logic [DIM-1:0] d = a ^ b;
    for (int i = 0; i < DIM; i++) if (d[i]) return PW'(1) << i;
    return PW'(1) << DIM;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_one(input logic [DIM-1:0] a, input logic [DIM-1:0] b);
    @(negedge clk);
    cur_addr = a; dst_addr = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(rsp_valid == 1'b0, "R7 rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R7 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_directed;
    send_one(4'b0000, 4'b0000);
    check(rsp_valid, "R5 valid one cycle after accept", int'(rsp_valid), 1);
    check(rsp_port == PW'(1) << DIM, "R3 local port on equal addresses", int'(rsp_port), 1 << DIM);
    check(rsp_hops == 0, "R3 zero hops on equal addresses", int'(rsp_hops), 0);
    send_one(4'b0101, 4'b1011);
    check(rsp_port == 5'b00010, "R2 lowest differing dimension", int'(rsp_port), 2);
    check(rsp_hops == 3, "R4 hop count", int'(rsp_hops), 3);
    send_one(4'b0000, 4'b1111);
    check(rsp_port == 5'b00001, "R2 dimension 0 first", int'(rsp_port), 1);
    check(rsp_hops == HW'(DIM), "R4 maximum distance", int'(rsp_hops), DIM);
    send_one(4'b0111, 4'b1111);
    check(rsp_port == 5'b01000, "R2 top dimension only", int'(rsp_port), 8);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 drains with no new request", int'(rsp_valid), 0);
  endtask

  task automatic t_sweep;
    for (int a = 0; a < NN; a++) begin
      for (int b = 0; b < NN; b++) begin
        logic [PW-1:0] ep;
        send_one(DIM'(a), DIM'(b));
        ep = exp_port(DIM'(a), DIM'(b));
        check(rsp_port == ep, "R2 sweep port", int'(rsp_port), int'(ep));
        check($countones(rsp_port) == 1, "R1 sweep one-hot", $countones(rsp_port), 1);
        check(int'(rsp_hops) == $countones(DIM'(a) ^ DIM'(b)), "R4 sweep hops",
              int'(rsp_hops), $countones(DIM'(a) ^ DIM'(b)));
      end
    end
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    cur_addr = 4'b0000; dst_addr = 4'b0100; req_valid = 1'b1;
    @(negedge clk);
    cur_addr = 4'b0011; dst_addr = 4'b0010;
    check(rsp_valid && rsp_port == 5'b00100, "R6 first decision presented", int'(rsp_port), 4);
    check(req_ready == 1'b0, "R6 req_ready low while stalled", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    check(rsp_port == 5'b00100 && rsp_hops == 1, "R6 decision held while stalled", int'(rsp_port), 4);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_port == 5'b00001, "R6 second decision after release", int'(rsp_port), 1);
    check(rsp_hops == 1, "R4 second decision hops", int'(rsp_hops), 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 empty after drain", int'(rsp_valid), 0);
  endtask

  task automatic t_chain;
    for (int a = 0; a < NN; a++) begin
      for (int b = 0; b < NN; b++) begin
        int hd = $countones(DIM'(a) ^ DIM'(b));
        int links = 0;
        bit local_ok = 1'b1;
        @(negedge clk);
        ch_src = DIM'(a); ch_dst = DIM'(b); ch_go = 1'b1;
        repeat (DIM + 3) @(negedge clk);
        for (int s = 0; s <= DIM; s++) begin
          if (!ch_port[s][DIM]) links++;
          if (s >= hd && !ch_port[s][DIM]) local_ok = 1'b0;
        end
        check(node_addr[DIM+1] == DIM'(b), "R8 chain reaches destination",
              int'(node_addr[DIM+1]), b);
        check(links == hd, "R8 link hops equal Hamming distance", links, hd);
        check(local_ok, "R8 local port once arrived", int'(local_ok), 1);
      end
    end
    ch_go = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_sweep();
    t_stall();
    t_chain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule